// File: doc/BRIEF.md
# Serial Control-Word Register Bank with Access Defaults

This block takes 24-bit control words from a three-wire serial port (serial clock, serial data, load strobe) and stores each word in one of eight registers. The three serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and all edges are found in the system clock domain. The word is shifted in most significant bit first. A rising edge on the load strobe commits the last 24 bits. The low nibble of the word selects the target register.

Registers 0 to 4 are mandatory. A `configured` output rises once each of them has been written since reset. Registers 5 to 7 are optional. A three-bit access field in register 3 puts each optional register either in programmable mode, where it shows the last value written, or in default mode, where it shows a fixed pattern set by a parameter. Register 3 also holds a reference divider value and a charge-gain code, and both are brought out as decoded results. Three error flags report a bad protocol word, an out-of-range divider and a strobe that arrived before a full word had been shifted in.

Top module: `sercfg_bank`

## Requirements
- R1: On each rising edge of `ser_clk`, `ser_data` is shifted in MSB first. A rising edge of `ser_load` commits the last 24 bits shifted in, even when more than 24 were sent.
- R2: The address is word[3:0]. It is valid only when bit 0 is 1, and then bits [3:1] give the register index. Register 3 is therefore selected by 0111. A word whose bit 0 is 0 changes no register.
- R3: One 24-bit transfer updates exactly one register and leaves the other seven outputs unchanged.
- R4: `configured` is 0 until registers 0, 1, 2, 3 and 4 have each been written at least once after reset, and it then stays 1.
- R5: In register 3, bit 21 controls register 5, bit 22 controls register 6 and bit 23 controls register 7. A value of 1 shows the last value written. A value of 0 shows the parameter default, whatever was written.
- R6: A write to register 3 with bit 20 equal to 0 sets `proto_err`. A later write to register 3 with bit 20 equal to 1 clears it. The write itself is stored in both cases.
- R7: `divider_r` equals register 3 bits [15:4]. A write to register 3 with that field below 3 sets `range_err`, and a write with that field at 3 or above clears it.
- R8: `gain_steps` equals register 3 bits [19:16] plus one, so codes 0 to 15 give 1 to 16.
- R9: A load strobe that comes after fewer than 24 shifted bits is ignored, and it sets `short_err`. The next load with 24 or more bits clears `short_err`.
- R10: After reset, registers 0 to 4 read zero, registers 5 to 7 read their defaults, and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_load | input | 1 | Load strobe, commits on its rising edge (asynchronous) |
| eff_regs | output | 8x24 | Effective contents of registers 0..7 |
| divider_r | output | 12 | Reference divider field of register 3 |
| gain_steps | output | 5 | Charge gain multiplier, 1..16 |
| configured | output | 1 | All mandatory registers written |
| proto_err | output | 1 | Last register-3 write had bit 20 clear |
| range_err | output | 1 | Last register-3 divider value was below 3 |
| short_err | output | 1 | Last load strobe came before a full word |

## Verification
A pin edge reaches the rise detector two system clocks later. The shift or commit happens on the third clock, so every register output, decoded field and flag is due three cycles after the `ser_load` pin rises. The bench holds `ser_data` for three clocks before each serial clock edge and holds each serial level for four clocks. After raising the strobe it waits six clocks and then samples at a falling clock edge. Every sample therefore lands after the due cycle and well before the next stimulus.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int WORD_W  = 24;
  localparam int NREG    = 8;
  localparam int NMAND   = 5;
  localparam int NOPT    = NREG - NMAND;
  localparam int IDX_W   = $clog2(NREG);
  localparam int DIV_W   = 12;
  localparam int DIV_LSB = 4;
  localparam int GAIN_W  = 4;
  localparam int GAIN_LSB = 16;
  localparam int ACC_LSB = 20;
  localparam int CTRL_IDX = 3;
  localparam int DIV_MIN = 3;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic addr_valid(input logic [3:0] a);
    return a[0];
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [3:0] a);
    return a[3:1];
  endfunction

  function automatic logic [GAIN_W:0] gain_mult(input logic [GAIN_W-1:0] code);
    return {1'b0, code} + {{GAIN_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic div_in_range(input logic [DIV_W-1:0] d);
    return d >= DIV_W'(DIV_MIN);
  endfunction
endpackage

// File: rtl/sercfg_sync_edge.sv
module sercfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
  import sercfg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_async,
  input  logic  shift_ev,
  input  logic  load_ev,
  output word_t word,
  output logic  full
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [STAGES-1:0] dpipe;
  logic [CNT_W-1:0]  count;
  logic              data_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dpipe <= '0;
    else        dpipe <= {dpipe[STAGES-2:0], data_async};
  end
  assign data_s = dpipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else begin
      if (shift_ev) word <= {word[WORD_W-2:0], data_s};
      if (load_ev)
        count <= '0;
      else if (shift_ev && count != CNT_W'(WORD_W))
        count <= count + 1'b1;
    end
  end

  assign full = (count == CNT_W'(WORD_W));

  p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> word[0] == $past(data_s));
  p_count_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !full);
endmodule

// File: rtl/sercfg_store.sv
module sercfg_store
  import sercfg_pkg::*;
#(
  parameter logic [NOPT-1:0][WORD_W-1:0] OPT_DEF = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_ev,
  input  logic                  full,
  input  word_t                 word,
  output logic [NREG-1:0][WORD_W-1:0] eff,
  output logic                  configured,
  output logic                  proto_err,
  output logic                  range_err,
  output logic                  short_err
);
  word_t          raw [NREG];
  logic [NMAND-1:0] written;
  logic           write_ev;
  logic           short_ev;
  logic [IDX_W-1:0] widx;
  logic           ctrl_write;

  assign write_ev   = load_ev && full && addr_valid(word[3:0]);
  assign short_ev   = load_ev && !full;
  assign widx       = addr_index(word[3:0]);
  assign ctrl_write = write_ev && (widx == IDX_W'(CTRL_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) raw[i] <= '0;
      written <= '0;
    end else if (write_ev) begin
      raw[widx] <= word;
      if (widx < IDX_W'(NMAND)) written[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_err <= 1'b0;
      range_err <= 1'b0;
      short_err <= 1'b0;
    end else begin
      if (ctrl_write) begin
        proto_err <= ~word[ACC_LSB];
        range_err <= ~div_in_range(word[DIV_LSB +: DIV_W]);
      end
      if (short_ev)              short_err <= 1'b1;
      else if (load_ev && full)  short_err <= 1'b0;
    end
  end

  assign configured = &written;

  for (genvar i = 0; i < NREG; i++) begin : g_eff
    if (i < NMAND) begin : g_mand
      assign eff[i] = raw[i];
    end else begin : g_opt
      assign eff[i] = raw[CTRL_IDX][ACC_LSB + 1 + i - NMAND] ? raw[i] : OPT_DEF[i-NMAND];
    end
  end

  p_cfg_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured);
  p_proto_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_write && !word[ACC_LSB]) |=> proto_err);
  p_range_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_write && word[DIV_LSB +: DIV_W] < DIV_W'(DIV_MIN)) |=> range_err);
  p_short_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_ev |=> ($stable(eff) && short_err));
  p_bad_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !addr_valid(word[3:0])) |=> $stable(eff));
endmodule

// File: rtl/sercfg_bank.sv
module sercfg_bank
  import sercfg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] DEF_R5 = 24'h00410B,
  parameter logic [WORD_W-1:0] DEF_R6 = 24'h00820D,
  parameter logic [WORD_W-1:0] DEF_R7 = 24'h00C30F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_load,
  output logic [NREG-1:0][WORD_W-1:0] eff_regs,
  output logic [DIV_W-1:0]           divider_r,
  output logic [GAIN_W:0]            gain_steps,
  output logic                       configured,
  output logic                       proto_err,
  output logic                       range_err,
  output logic                       short_err
);
  logic  sclk_rise;
  logic  load_rise;
  logic  full;
  word_t word;

  sercfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .rise(sclk_rise));

  sercfg_sync_edge #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ser_load), .rise(load_rise));

  sercfg_shifter #(.STAGES(SYNC_STAGES)) u_shifter (
    .clk(clk), .rst_n(rst_n), .data_async(ser_data),
    .shift_ev(sclk_rise), .load_ev(load_rise), .word(word), .full(full));

  sercfg_store #(.OPT_DEF({DEF_R7, DEF_R6, DEF_R5})) u_store (
    .clk(clk), .rst_n(rst_n), .load_ev(load_rise), .full(full), .word(word),
    .eff(eff_regs), .configured(configured), .proto_err(proto_err),
    .range_err(range_err), .short_err(short_err));

  assign divider_r  = eff_regs[CTRL_IDX][DIV_LSB +: DIV_W];
  assign gain_steps = gain_mult(eff_regs[CTRL_IDX][GAIN_LSB +: GAIN_W]);

  p_gain_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gain_steps != '0);
endmodule

// File: tb/sercfg_bank_tb.sv
module sercfg_bank_tb;
  localparam logic [23:0] D5 = 24'h00410B;
  localparam logic [23:0] D6 = 24'h00820D;
  localparam logic [23:0] D7 = 24'h00C30F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [7:0][23:0] eff_regs;
  logic [11:0] divider_r;
  logic [4:0]  gain_steps;
  logic configured, proto_err, range_err, short_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] model [8];

  always #10 clk = ~clk;

  sercfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .eff_regs(eff_regs), .divider_r(divider_r),
    .gain_steps(gain_steps), .configured(configured), .proto_err(proto_err),
    .range_err(range_err), .short_err(short_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_eff(input int i);
    logic [23:0] d;
    d = (i == 5) ? D5 : (i == 6) ? D6 : D7;
    if (i < 5) return model[i];
    return model[3][16+i] ? model[i] : d;
  endfunction

  task automatic chk_all(input string req);
    logic ok = 1'b1;
    checks++;
    for (int i = 0; i < 8; i++)
      if (eff_regs[i] !== exp_eff(i)) begin
        ok = 1'b0;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, i, eff_regs[i], exp_eff(i));
      end
    if (!ok) errors++;
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = bits[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk); ser_load = 1'b1;
    repeat (6) @(negedge clk); ser_load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w);
    shift_bits({8'h0, w}, 24);
    if (w[0]) model[w[3:1]] = w;
  endtask

  function automatic logic [23:0] ctrl(input logic [3:0] acc, input logic [3:0] g,
                                       input logic [11:0] div);
    return {acc, g, div, 4'b0111};
  endfunction

  task automatic t_reset;
    chk_all("R10 reset regs");
    chk("R10 reset configured", configured, 0);
    chk("R10 reset flags", {proto_err, range_err, short_err}, 0);
  endtask

  task automatic t_mandatory;
    send(24'h123451);
    send(24'hABCDE3);
    send(24'h5A5A55);
    chk("R4 not yet configured", configured, 0);
    send(24'h0F0F09);
    chk("R4 still missing reg3", configured, 0);
    send(ctrl(4'b0001, 4'd2, 12'd100));
    chk("R4 configured", configured, 1);
    chk_all("R1 R2 stored values");
  endtask

  task automatic t_access;
    send(24'hFEDCBB);
    chk("R5 default while disabled", eff_regs[5], D5);
    send(ctrl(4'b1011, 4'd2, 12'd100));
    chk("R5 reg5 programmable", eff_regs[5], 24'hFEDCBB);
    chk("R5 reg6 default", eff_regs[6], D6);
    chk("R5 reg7 programmable unwritten", eff_regs[7], 0);
    send(24'h13579F);
    chk("R5 reg7 written", eff_regs[7], 24'h13579F);
    send(ctrl(4'b0001, 4'd2, 12'd100));
    chk_all("R5 back to defaults");
    send(ctrl(4'b1111, 4'd2, 12'd100));
  endtask

  task automatic t_isolation;
    send(24'h777773);
    chk_all("R3 single write isolation");
    chk("R4 configured kept", configured, 1);
  endtask

  task automatic t_proto;
    send(ctrl(4'b1110, 4'd1, 12'd50));
    chk("R6 proto err set", proto_err, 1);
    chk_all("R6 write stored");
    send(ctrl(4'b1111, 4'd1, 12'd50));
    chk("R6 proto err cleared", proto_err, 0);
  endtask

  task automatic t_range;
    send(ctrl(4'b1111, 4'd0, 12'd2));
    chk("R7 range err low", range_err, 1);
    chk("R7 divider out", divider_r, 2);
    send(ctrl(4'b1111, 4'd0, 12'd3));
    chk("R7 range ok at 3", range_err, 0);
    send(ctrl(4'b1111, 4'd0, 12'd4095));
    chk("R7 range ok max", range_err, 0);
    chk("R7 divider max", divider_r, 4095);
  endtask

  task automatic t_gain;
    send(ctrl(4'b1111, 4'd0, 12'd10));
    chk("R8 gain code 0", gain_steps, 1);
    send(ctrl(4'b1111, 4'd15, 12'd10));
    chk("R8 gain code 15", gain_steps, 16);
    send(ctrl(4'b1111, 4'd6, 12'd10));
    chk("R8 gain code 6", gain_steps, 7);
  endtask

  task automatic t_short;
    shift_bits(32'h000003FF, 10);
    chk("R9 short err set", short_err, 1);
    chk_all("R9 short ignored");
    send(24'h2468AD);
    chk("R9 short err cleared", short_err, 0);
    chk_all("R9 full word after short");
  endtask

  task automatic t_bad_addr;
    shift_bits({8'h0, 24'hFFFFF6}, 24);
    chk_all("R2 even address ignored");
  endtask

  task automatic t_overlong;
    shift_bits({8'hA5, 24'h31415B}, 32);
    model[5] = 24'h31415B;
    chk_all("R1 last 24 bits kept");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_mandatory;
    t_access;
    t_isolation;
    t_proto;
    t_range;
    t_gain;
    t_short;
    t_bad_addr;
    t_overlong;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule